// File: doc/BRIEF.md
# Switch-Tuned Chroma Key Filter

This block sits in a live RGB565 video path and blanks out background pixels whose colour is close to a chosen key colour. Each incoming pixel is compared with the key one colour channel at a time. A pixel is keyed when every channel lies within a limit chosen by a two-bit sensitivity code, and a keyed pixel is replaced with black. All other pixels go through unchanged. The stage has a fixed two-cycle latency, and its output valid flag is delayed to stay aligned with the pixel.

The key colour and the sensitivity code are read live from an 18-bit bank of slide switches. Seven seven-segment digits show the current setting, so an operator can tune it by eye. There are two push-buttons for tuning. One, while held, replaces every output pixel with the key colour so the key can be compared with the real backdrop. The other, while held, disables the filter. Both buttons are active-low and go through a two-flop synchroniser. When both are held, preview takes precedence.

Top module: `chroma_keyer`

## Requirements
- R1: While reset is applied and after it is released with no input, `o_valid` stays low.
- R2: The switches are decoded as red = sw[15:11], green = sw[10:5], blue = sw[4:0], sensitivity code = sw[17:16]. A pixel is packed as red [15:11], green [10:5], blue [4:0].
- R3: In filter mode a pixel is keyed when all of these hold: 2*|red-keyred| <= L, |green-keygreen| <= L, and 2*|blue-keyblue| <= L. A keyed pixel is output as 16'h0000.
- R4: In filter mode a pixel that fails any one of the three channel tests in R3 is output unchanged.
- R5: Sensitivity codes 0, 1, 2 and 3 give L = 0, 2, 4 and 8. Code 0 therefore keys only an exact match.
- R6: While the preview button (active-low) is held, every valid output pixel equals the key colour packed as in R2. This holds whatever the bypass button does.
- R7: While only the bypass button (active-low) is held, every valid output pixel equals its input pixel.
- R8: A pixel presented with `i_valid` high at clock edge n appears with `o_valid` high after edge n+2. An input cycle with `i_valid` low gives `o_valid` low two cycles later.
- R9: `o_seg` carries seven digits of seven active-low segments each. In every digit, bits 0 to 6 drive segments a to g, and a 0 lights the segment. The digits are laid out from index 6 down to 0: red high, red low, green high, green low, blue high, blue low, sensitivity code. Each colour field is zero-extended to 8 bits and shown as two hexadecimal digits. The code is shown as one digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_pixel | input | 16 | Incoming RGB565 pixel |
| i_valid | input | 1 | Incoming pixel qualifier |
| i_sw | input | 18 | Slide switches: key colour and sensitivity |
| i_btn_preview_n | input | 1 | Key-colour preview button, active-low |
| i_btn_bypass_n | input | 1 | Filter bypass button, active-low |
| o_pixel | output | 16 | Filtered pixel |
| o_valid | output | 1 | Output pixel qualifier, two cycles after input |
| o_seg | output | 49 | Seven active-low seven-segment digit patterns |

## Verification
A wrong limit entry or a wrong scaling of red or blue shifts the keying boundary by a step or more. The bench sweeps offsets well past every limit around two key colours, so such a fault shows at once as black pixels that should have passed, or passed pixels that should be black, on the first pixel that crosses that boundary. A misrouted mode bit or a wrong priority corrupts every valid pixel within three cycles of the button change. A fault in the valid pipeline shows on the first idle slot in the stream, since idle slots are mixed into the stream at intervals. The segment decode is purely combinational from the switches, so a wrong pattern is visible as soon as the switches settle.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

  localparam int RED_W   = 5;
  localparam int GRN_W   = 6;
  localparam int BLU_W   = 5;
  localparam int PIX_W   = RED_W + GRN_W + BLU_W;
  localparam int THR_W   = 2;
  localparam int SW_W    = PIX_W + THR_W;
  localparam int SEG_W   = 7;
  localparam int DIGITS  = 7;
  localparam int CMP_W   = GRN_W;

  typedef struct packed {
    logic [RED_W-1:0] r;
    logic [GRN_W-1:0] g;
    logic [BLU_W-1:0] b;
  } rgb565_t;

  typedef enum logic [1:0] {
    MODE_FILTER  = 2'd0,
    MODE_BYPASS  = 2'd1,
    MODE_PREVIEW = 2'd2
  } key_mode_e;

  function automatic logic [CMP_W-1:0] limit_of(input logic [THR_W-1:0] code);
    logic [CMP_W-1:0] lim;
    case (code)
      2'd0:    lim = 6'd0;
      2'd1:    lim = 6'd2;
      2'd2:    lim = 6'd4;
      default: lim = 6'd8;
    endcase
    return lim;
  endfunction

  function automatic logic [CMP_W-1:0] abs_diff(input logic [CMP_W-1:0] a,
                                                input logic [CMP_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // active-low, bit0 = segment a ... bit6 = segment g
  function automatic logic [SEG_W-1:0] hex_to_seg(input logic [3:0] h);
    logic [SEG_W-1:0] lit;
    case (h)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/ckey_btn_sync.sv
module ckey_btn_sync #(
  parameter int N_BTN  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_BTN-1:0] i_btn_n,
  output logic [N_BTN-1:0] o_pressed
);

  logic [N_BTN-1:0] chain_q [STAGES];
  logic [N_BTN-1:0] chain_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = i_btn_n;
      end else begin : g_rest
        always_comb chain_d[s] = chain_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= {N_BTN{1'b1}};
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign o_pressed = ~chain_q[STAGES-1];

endmodule

// File: rtl/ckey_match.sv
module ckey_match
  import ckey_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] i_pixel,
  input  logic             i_valid,
  input  rgb565_t          i_key,
  input  logic [THR_W-1:0] i_thr,
  output logic [PIX_W-1:0] o_pixel,
  output logic             o_valid,
  output logic             o_hit
);

  rgb565_t          px;
  logic [CMP_W-1:0] lim;
  logic [CMP_W-1:0] d_r, d_g, d_b;
  logic             hit_d;

  logic [PIX_W-1:0] pix_q, pix_d;
  logic             vld_q;
  logic             hit_q, hit_q_d;

  always_comb begin
    px    = rgb565_t'(i_pixel);
    lim   = limit_of(i_thr);
    d_r   = abs_diff({px.r, 1'b0}, {i_key.r, 1'b0});
    d_g   = abs_diff(px.g, i_key.g);
    d_b   = abs_diff({px.b, 1'b0}, {i_key.b, 1'b0});
    hit_d = (d_r <= lim) && (d_g <= lim) && (d_b <= lim);
    pix_d   = i_valid ? i_pixel : pix_q;
    hit_q_d = i_valid ? hit_d   : hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      vld_q <= i_valid;
      hit_q <= hit_q_d;
    end
  end

  assign o_pixel = pix_q;
  assign o_valid = vld_q;
  assign o_hit   = hit_q;

  AST_EXACT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && hit_q && $past(i_thr) == 2'd0) |-> (pix_q == $past(i_key))); // R5

endmodule

// File: rtl/ckey_seg_bank.sv
module ckey_seg_bank
  import ckey_pkg::*;
(
  input  rgb565_t                  i_key,
  input  logic [THR_W-1:0]         i_thr,
  output logic [DIGITS*SEG_W-1:0]  o_seg
);

  logic [7:0] red8, grn8, blu8;
  logic [3:0] nib [DIGITS];

  always_comb begin
    red8   = {{(8-RED_W){1'b0}}, i_key.r};
    grn8   = {{(8-GRN_W){1'b0}}, i_key.g};
    blu8   = {{(8-BLU_W){1'b0}}, i_key.b};
    nib[6] = red8[7:4];
    nib[5] = red8[3:0];
    nib[4] = grn8[7:4];
    nib[3] = grn8[3:0];
    nib[2] = blu8[7:4];
    nib[1] = blu8[3:0];
    nib[0] = {{(4-THR_W){1'b0}}, i_thr};
  end

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_digit
      assign o_seg[d*SEG_W +: SEG_W] = hex_to_seg(nib[d]);
    end
  endgenerate

endmodule

// File: rtl/chroma_keyer.sv
module chroma_keyer
  import ckey_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] i_pixel,
  input  logic        i_valid,
  input  logic [17:0] i_sw,
  input  logic        i_btn_preview_n,
  input  logic        i_btn_bypass_n,
  output logic [15:0] o_pixel,
  output logic        o_valid,
  output logic [48:0] o_seg
);

  localparam int SYNC_STAGES = 2;
  localparam int N_BTN       = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // switch decode
  rgb565_t          key;
  logic [THR_W-1:0] thr;

  always_comb begin
    key = rgb565_t'(i_sw[PIX_W-1:0]);
    thr = i_sw[SW_W-1:PIX_W];
  end

  // buttons
  logic [N_BTN-1:0] pressed;
  key_mode_e        mode;

  ckey_btn_sync #(.N_BTN(N_BTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .i_btn_n   ({i_btn_bypass_n, i_btn_preview_n}),
    .o_pressed (pressed)
  );

  always_comb begin
    if (pressed[0])      mode = MODE_PREVIEW;
    else if (pressed[1]) mode = MODE_BYPASS;
    else                 mode = MODE_FILTER;
  end

  // stage 1: compare
  logic [PIX_W-1:0] s1_pixel;
  logic             s1_valid;
  logic             s1_hit;

  ckey_match u_match (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .i_pixel (i_pixel),
    .i_valid (i_valid),
    .i_key   (key),
    .i_thr   (thr),
    .o_pixel (s1_pixel),
    .o_valid (s1_valid),
    .o_hit   (s1_hit)
  );

  // stage 2: select
  logic [PIX_W-1:0] sel_pix;
  logic [PIX_W-1:0] out_pix_q, out_pix_d;
  logic             out_vld_q;

  always_comb begin
    case (mode)
      MODE_PREVIEW: sel_pix = key;
      MODE_BYPASS:  sel_pix = s1_pixel;
      default:      sel_pix = s1_hit ? '0 : s1_pixel;
    endcase
    out_pix_d = s1_valid ? sel_pix : out_pix_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_pix_q <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_pix_q <= out_pix_d;
      out_vld_q <= s1_valid;
    end
  end

  assign o_pixel = out_pix_q;
  assign o_valid = out_vld_q;

  // readout
  ckey_seg_bank u_seg (
    .i_key (key),
    .i_thr (thr),
    .o_seg (o_seg)
  );

  // cycles since reset, for the history-based checks below
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)         age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (age_q == 2'd2) |-> (o_valid == $past(i_valid, 2))); // R8

  AST_PREVIEW_KEY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (o_valid && $past(mode == MODE_PREVIEW)) |-> (o_pixel == $past(i_sw[PIX_W-1:0]))); // R6

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (age_q == 2'd2 && o_valid && $past(mode == MODE_BYPASS)) |-> (o_pixel == $past(i_pixel, 2))); // R7

  AST_KEYED_BLACK: assert property (@(posedge clk) disable iff (!rst_n_int)
    (o_valid && $past(mode == MODE_FILTER && s1_hit)) |-> (o_pixel == 16'h0000)); // R3

endmodule

// File: tb/chroma_keyer_tb_top.sv
`timescale 1ns/1ps
module chroma_keyer_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] i_pixel;
  logic        i_valid;
  logic [17:0] i_sw;
  logic        btn_prv_n;
  logic        btn_byp_n;
  logic [15:0] o_pixel;
  logic        o_valid;
  logic [48:0] o_seg;

  int checks = 0;
  int errors = 0;

  chroma_keyer dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .i_pixel         (i_pixel),
    .i_valid         (i_valid),
    .i_sw            (i_sw),
    .i_btn_preview_n (btn_prv_n),
    .i_btn_bypass_n  (btn_byp_n),
    .o_pixel         (o_pixel),
    .o_valid         (o_valid),
    .o_seg           (o_seg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bench model state
  int kr, kg, kb, kt;
  bit prv, byp;
  // expectation pipeline (two stages)
  bit      ev1, ev2;
  int      ep1, ep2;
  string   et1, et2;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int lim_for(input int code);
    return (code == 0) ? 0 : (1 << code);
  endfunction

  task automatic expect_for(input int p, output int e, output string tag);
    int r, g, b, l;
    r = (p >> 11) & 31; g = (p >> 5) & 63; b = p & 31;
    l = lim_for(kt);
    if (prv) begin
      e = (kr << 11) | (kg << 5) | kb; tag = "R6";
    end else if (byp) begin
      e = p; tag = "R7";
    end else if (2*iabs(r-kr) <= l && iabs(g-kg) <= l && 2*iabs(b-kb) <= l) begin
      e = 0; tag = "R3/R5";
    end else begin
      e = p; tag = "R4/R2";
    end
  endtask

  task automatic step(input int p, input bit v);
    int    e;
    string tag;
    @(negedge clk);
    checks++;
    if (o_valid !== ev2) begin
      errors++;
      $display("FAIL R8 valid actual %0b expected %0b", o_valid, ev2);
    end
    if (ev2) begin
      checks++;
      if (o_pixel !== ep2[15:0]) begin
        errors++;
        $display("FAIL %s pixel actual %h expected %h", et2, o_pixel, ep2[15:0]);
      end
    end
    expect_for(p, e, tag);
    ev2 = ev1; ep2 = ep1; et2 = et1;
    ev1 = v;   ep1 = e;   et1 = tag;
    i_pixel = p[15:0];
    i_valid = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 1'b0);
  endtask

  task automatic set_cfg(input int r, input int g, input int b, input int t,
                         input bit pv, input bit bp);
    idle(3);
    kr = r; kg = g; kb = b; kt = t; prv = pv; byp = bp;
    i_sw      = {t[1:0], r[4:0], g[5:0], b[4:0]};
    btn_prv_n = ~pv;
    btn_byp_n = ~bp;
    idle(4);
  endtask

  function automatic logic [6:0] exp_seg(input int h);
    logic [6:0] on;
    case (h)
      0: on = 7'b0111111;  1: on = 7'b0000110;  2: on = 7'b1011011;  3: on = 7'b1001111;
      4: on = 7'b1100110;  5: on = 7'b1101101;  6: on = 7'b1111101;  7: on = 7'b0000111;
      8: on = 7'b1111111;  9: on = 7'b1101111; 10: on = 7'b1110111; 11: on = 7'b1111100;
      12: on = 7'b0111001; 13: on = 7'b1011110; 14: on = 7'b1111001; default: on = 7'b1110001;
    endcase
    return ~on;
  endfunction

  task automatic check_segs();
    int nib [7];
    nib[6] = kr >> 4; nib[5] = kr & 15;
    nib[4] = kg >> 4; nib[3] = kg & 15;
    nib[2] = kb >> 4; nib[1] = kb & 15;
    nib[0] = kt;
    for (int d = 0; d < 7; d++) begin
      checks++;
      if (o_seg[d*7 +: 7] !== exp_seg(nib[d])) begin
        errors++;
        $display("FAIL R9 digit %0d actual %b expected %b", d, o_seg[d*7 +: 7], exp_seg(nib[d]));
      end
    end
  endtask

  task automatic sweep_key(input int r0, input int g0, input int b0);
    int n;
    n = 0;
    for (int dr = -5; dr <= 5; dr++)
      for (int dg = -9; dg <= 9; dg++)
        for (int db = -5; db <= 5; db++) begin
          int r, g, b;
          r = r0 + dr; g = g0 + dg; b = b0 + db;
          if (r >= 0 && r < 32 && g >= 0 && g < 64 && b >= 0 && b < 32) begin
            n++;
            if (n % 7 == 0) step(16'hA5A5, 1'b0);
            step((r << 11) | (g << 5) | b, 1'b1);
          end
        end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog R8 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    rst_n = 1'b0; i_pixel = '0; i_valid = 1'b0; i_sw = '0;
    btn_prv_n = 1'b1; btn_byp_n = 1'b1;
    kr = 0; kg = 0; kb = 0; kt = 0; prv = 0; byp = 0;
    ev1 = 0; ev2 = 0; ep1 = 0; ep2 = 0; et1 = "R8"; et2 = "R8";
    repeat (3) @(negedge clk);
    checks++;
    if (o_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid in reset actual %0b expected 0", o_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (o_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid after reset actual %0b expected 0", o_valid);
    end

    // R3 R4 R5 R2: sweeps around a mid key and an edge key for each code
    for (int t = 0; t < 4; t++) begin
      set_cfg(16, 32, 16, t, 0, 0);
      #1 check_segs();
      sweep_key(16, 32, 16);
      set_cfg(2, 60, 29, t, 0, 0);
      #1 check_segs();
      sweep_key(2, 60, 29);
    end

    // R9 readout on assorted switch patterns
    set_cfg(31, 63, 31, 3, 0, 0); #1 check_segs();
    set_cfg(10, 43, 5, 1, 0, 0);  #1 check_segs();
    set_cfg(0, 0, 0, 0, 0, 0);    #1 check_segs();

    // broad pseudo-random stream in filter mode
    set_cfg(7, 21, 12, 3, 0, 0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      step(lfsr, (i % 5) != 4);
    end

    // R6 preview, R7 bypass, R6 priority with both held
    set_cfg(9, 40, 20, 2, 1, 0);
    for (int i = 0; i < 200; i++) step(i * 331, 1'b1);
    set_cfg(9, 40, 20, 2, 0, 1);
    for (int i = 0; i < 200; i++) step((9 << 11) | (40 << 5) | 20 + (i & 1), 1'b1);
    set_cfg(9, 40, 20, 2, 1, 1);
    for (int i = 0; i < 200; i++) step(i * 977, (i % 3) != 0);
    set_cfg(9, 40, 20, 2, 0, 0);
    for (int i = 0; i < 100; i++) step((9 << 11) | (40 << 5) | 20, 1'b1);

    // R8 drain
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule